// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and letting a third table decide, per branch, which of them to trust. The first predictor keeps a private outcome history for each branch, selected by low instruction-address bits, and uses that history to pick a 3-bit saturating counter. The second uses one shared history of the most recent outcomes, across all branches, to pick a 2-bit counter. A table of 2-bit choice counters, indexed by the same shared history, selects the final answer.

A lookup is purely combinational. The fetch stage presents an address and receives the final direction together with the two component directions and the choice bit, which it keeps with the branch. When the branch resolves, the update port receives the address, the real outcome and the saved component directions. The block then trains every table and shifts both histories. Training happens at the clock edge, so a lookup in the same cycle as an update still sees the state from before that update.

Top module: `hyb_tournament_predictor`

## Requirements
- R1: After a synchronous active-high reset, every per-branch history and the shared history are zero, every 3-bit local counter is 3, every shared-history counter is 2'b01, and every choice counter is 2'b01. A lookup then returns 0 on all four outputs.
- R2: The local direction is the most significant bit of the 3-bit counter indexed by the 10-bit per-branch history. That history is selected by address bits [11:2].
- R3: The global direction is the most significant bit of the 2-bit counter indexed by the 12-bit shared history. The choice output is the most significant bit of the choice counter at that same index.
- R4: The final direction equals the global direction when the choice output is 1 and the local direction when it is 0.
- R5: On an update, the per-branch history selected by the update address shifts left by one and takes the outcome into bit 0, with 1 meaning taken and 0 meaning not taken.
- R6: On an update, the local counter indexed by that branch's pre-update history goes up by one when taken and down by one when not taken, saturating at 0 and 7.
- R7: On an update, the shared-history counter at the pre-update shared history moves toward the outcome and saturates at 0 and 3. The shared history then shifts left and takes the outcome into bit 0.
- R8: The choice counter at the pre-update shared history changes only when the supplied local and global directions differ. It goes up, saturating at 3, when the global direction matched the outcome, and down, saturating at 0, when it did not.
- R9: A cycle without an update valid leaves all predictor state unchanged, whatever address is looked up.
- R10: An update takes effect from the next cycle on. A lookup in the same cycle returns the pre-update state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Address looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_local | output | 1 | Local component direction |
| lk_global | output | 1 | Global component direction |
| lk_use_global | output | 1 | Choice bit, 1 selects global |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 taken |
| up_local | input | 1 | Local direction saved at lookup |
| up_global | input | 1 | Global direction saved at lookup |

## Verification
The choice assertions assume that the saved component directions on the update port are the ones the block produced for that branch. The shared-history checks also assume that updates arrive in the order of the shared history. The stimulus meets both assumptions by taking the component bits for every update from the reference model's prediction for the update address, in the same cycle and with nothing in flight. This holds even when the lookup address differs from the update address or two addresses alias on bits [11:2].

// File: rtl/hyb_pred_pkg.sv
package hyb_pred_pkg;

    typedef enum logic [1:0] {
        CH_STRONG_LOCAL  = 2'b00,
        CH_WEAK_LOCAL    = 2'b01,
        CH_WEAK_GLOBAL   = 2'b10,
        CH_STRONG_GLOBAL = 2'b11
    } choice_e;

    localparam logic [1:0] GCTR_INIT = 2'b01;

    typedef struct packed {
        logic local_dir;
        logic global_dir;
        logic use_global;
        logic final_dir;
    } pred_out_t;

    typedef struct packed {
        logic valid;
        logic taken;
        logic local_dir;
        logic global_dir;
    } train_t;

    // Saturating step of a counter of at most 8 bits toward up/down.
    function automatic logic [7:0] sat_step(logic [7:0] cur, logic up, int unsigned maxv);
        logic [7:0] r;
        if (up) r = (cur == 8'(maxv)) ? cur : cur + 8'd1;
        else    r = (cur == 8'd0)     ? cur : cur - 8'd1;
        return r;
    endfunction

endpackage

// File: rtl/hyb_local_pred.sv
module hyb_local_pred
    import hyb_pred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int IDX_BITS  = 10,
    parameter int HIST_BITS = 10,
    parameter int CTR_BITS  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_dir,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int HT_DEPTH = 1 << IDX_BITS;
    localparam int PT_DEPTH = 1 << HIST_BITS;
    localparam int CTR_MAX  = (1 << CTR_BITS) - 1;
    localparam int CTR_INIT = (1 << (CTR_BITS - 1)) - 1;

    logic [HIST_BITS-1:0] hist_q [HT_DEPTH];
    logic [CTR_BITS-1:0]  ctr_q  [PT_DEPTH];

    logic [IDX_BITS-1:0]  lk_idx, up_idx;
    logic [HIST_BITS-1:0] lk_hist, up_hist;
    logic [CTR_BITS-1:0]  ctr_next;

    always_comb begin
        lk_idx   = lk_pc[PC_LSB +: IDX_BITS];
        up_idx   = up_pc[PC_LSB +: IDX_BITS];
        lk_hist  = hist_q[lk_idx];
        up_hist  = hist_q[up_idx];
        lk_dir   = ctr_q[lk_hist][CTR_BITS-1];
        ctr_next = CTR_BITS'(sat_step(8'(ctr_q[up_hist]), up_taken, CTR_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HT_DEPTH; i++) hist_q[i] <= '0;
            for (int j = 0; j < PT_DEPTH; j++) ctr_q[j] <= CTR_BITS'(CTR_INIT);
        end else if (up_valid) begin
            hist_q[up_idx]  <= {up_hist[HIST_BITS-2:0], up_taken};
            ctr_q[up_hist]  <= ctr_next;
        end
    end

    // R5
    hist_insert_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> hist_q[$past(up_idx)][0] == $past(up_taken));

    // R6
    lctr_top_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken && ctr_q[up_hist] == CTR_BITS'(CTR_MAX))
        |=> ctr_q[$past(up_hist)] == CTR_BITS'(CTR_MAX));

    // R6
    lctr_floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (up_valid && !up_taken && ctr_q[up_hist] == '0)
        |=> ctr_q[$past(up_hist)] == '0);

endmodule

// File: rtl/hyb_global_pred.sv
module hyb_global_pred
    import hyb_pred_pkg::*;
#(
    parameter int GH_BITS = 12
) (
    input  logic               clk,
    input  logic               rst,
    output logic [GH_BITS-1:0] ghist,
    output logic               lk_dir,
    input  logic               up_valid,
    input  logic               up_taken
);
    localparam int DEPTH = 1 << GH_BITS;

    logic [GH_BITS-1:0] ghr_q;
    logic [1:0]         ctr_q [DEPTH];
    logic [1:0]         ctr_next;

    always_comb begin
        ghist    = ghr_q;
        lk_dir   = ctr_q[ghr_q][1];
        ctr_next = 2'(sat_step(8'(ctr_q[ghr_q]), up_taken, 3));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ghr_q <= '0;
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= GCTR_INIT;
        end else if (up_valid) begin
            ctr_q[ghr_q] <= ctr_next;
            ghr_q        <= {ghr_q[GH_BITS-2:0], up_taken};
        end
    end

    // R9
    ghist_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(ghr_q));

    // R7
    ghist_insert_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> ghr_q[0] == $past(up_taken));

endmodule

// File: rtl/hyb_choice_table.sv
module hyb_choice_table
    import hyb_pred_pkg::*;
#(
    parameter int GH_BITS = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GH_BITS-1:0] ghist,
    output logic               use_global,
    input  train_t             trn
);
    localparam int DEPTH = 1 << GH_BITS;

    logic [1:0] ctr_q [DEPTH];
    logic       disagree, global_right;
    logic [1:0] ctr_next;

    always_comb begin
        use_global   = ctr_q[ghist][1];
        disagree     = trn.local_dir != trn.global_dir;
        global_right = trn.global_dir == trn.taken;
        ctr_next     = 2'(sat_step(8'(ctr_q[ghist]), global_right, 3));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CH_WEAK_LOCAL;
        end else if (trn.valid && disagree) begin
            ctr_q[ghist] <= ctr_next;
        end
    end

    // R8
    choice_agree_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trn.valid && trn.local_dir == trn.global_dir)
        |=> ctr_q[$past(ghist)] == $past(ctr_q[ghist]));

    // R8
    choice_toward_global_chk: assert property (@(posedge clk) disable iff (rst)
        (trn.valid && disagree && trn.global_dir == trn.taken && ctr_q[ghist] != 2'b11)
        |=> ctr_q[$past(ghist)] == $past(ctr_q[ghist]) + 2'd1);

endmodule

// File: rtl/hyb_tournament_predictor.sv
module hyb_tournament_predictor
    import hyb_pred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LIDX_BITS = 10,
    parameter int LHIST_BITS = 10,
    parameter int LCTR_BITS = 3,
    parameter int GH_BITS   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_local,
    output logic            lk_global,
    output logic            lk_use_global,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_local,
    input  logic            up_global
);
    logic [GH_BITS-1:0] ghist;
    pred_out_t          pred;
    train_t             trn;

    assign trn = '{valid: up_valid, taken: up_taken,
                   local_dir: up_local, global_dir: up_global};

    hyb_local_pred #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_BITS(LIDX_BITS),
        .HIST_BITS(LHIST_BITS), .CTR_BITS(LCTR_BITS)
    ) u_local (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_dir(pred.local_dir),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    hyb_global_pred #(.GH_BITS(GH_BITS)) u_global (
        .clk(clk), .rst(rst), .ghist(ghist), .lk_dir(pred.global_dir),
        .up_valid(up_valid), .up_taken(up_taken)
    );

    hyb_choice_table #(.GH_BITS(GH_BITS)) u_choice (
        .clk(clk), .rst(rst), .ghist(ghist),
        .use_global(pred.use_global), .trn(trn)
    );

    assign pred.final_dir = pred.use_global ? pred.global_dir : pred.local_dir;

    assign lk_taken      = pred.final_dir;
    assign lk_local      = pred.local_dir;
    assign lk_global     = pred.global_dir;
    assign lk_use_global = pred.use_global;

    // R4
    always_comb begin
        if (!rst && lk_local == lk_global)
            agree_final_chk: assert (lk_taken == lk_local);
    end

endmodule

// File: tb/tb_hyb_tournament_predictor.sv
module tb_hyb_tournament_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0, up_pc = '0;
    logic        lk_taken, lk_local, lk_global, lk_use_global;
    logic        up_valid = 1'b0, up_taken = 1'b0, up_local = 1'b0, up_global = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_lht [1024];
    int m_lpt [1024];
    int m_gpt [4096];
    int m_cpt [4096];
    int m_ghr;

    always #4 clk = ~clk;

    hyb_tournament_predictor dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_local(lk_local), .lk_global(lk_global), .lk_use_global(lk_use_global),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_local(up_local), .up_global(up_global)
    );

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v < mx) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    // Reference prediction from the requirement text (R2, R3, R4)
    task automatic model_pred(input logic [31:0] pc, output bit l, output bit g,
                              output bit c, output bit f);
        int h;
        h = m_lht[(pc >> 2) & 1023];
        l = m_lpt[h] >= 4;
        g = m_gpt[m_ghr] >= 2;
        c = m_cpt[m_ghr] >= 2;
        f = c ? g : l;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin m_lht[i] = 0; m_lpt[i] = 3; end
        for (int i = 0; i < 4096; i++) begin m_gpt[i] = 1; m_cpt[i] = 1; end
        m_ghr = 0;
    endtask

    task automatic chk(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: lookup lpc, optional update of upc with outcome t
    task automatic step(logic [31:0] lpc, bit uv, logic [31:0] upc, bit t);
        bit l, g, c, f, ul, ug, uc, uf;
        int li, h;
        @(negedge clk);
        model_pred(upc, ul, ug, uc, uf);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = t;
        up_local = ul; up_global = ug;
        #1;
        // R10: same-cycle lookup sees pre-update state
        model_pred(lpc, l, g, c, f);
        chk("R2 local", lk_local, l);
        chk("R3 global", lk_global, g);
        chk("R3 choice", lk_use_global, c);
        chk("R4 final", lk_taken, f);
        if (uv) begin
            // R5 R6 R7 R8
            li = (upc >> 2) & 1023;
            h = m_lht[li];
            m_lpt[h] = sat(m_lpt[h], t, 7);
            m_lht[li] = ((h << 1) | int'(t)) & 1023;
            if (ul != ug) m_cpt[m_ghr] = sat(m_cpt[m_ghr], ug == t, 3);
            m_gpt[m_ghr] = sat(m_gpt[m_ghr], t, 3);
            m_ghr = ((m_ghr << 1) | int'(t)) & 4095;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        lk_pc = 32'h4000_0100;
        #1;
        // R1: reset values give all-zero outputs
        chk("R1 local", lk_local, 1'b0);
        chk("R1 global", lk_global, 1'b0);
        chk("R1 choice", lk_use_global, 1'b0);
        chk("R1 final", lk_taken, 1'b0);

        // Loop-like branch: three taken, one not taken
        for (int i = 0; i < 200; i++)
            step(32'h4000_0100, 1, 32'h4000_0100, (i % 4) != 3);
        // Alternating branch
        for (int i = 0; i < 100; i++)
            step(32'h4000_0200, 1, 32'h4000_0200, i[0]);
        // R9: idle cycles with varied lookups change nothing
        for (int i = 0; i < 40; i++)
            step(32'h4000_0000 + 32'(i * 4), 0, 32'h4000_0100, 1'b1);
        // R6: saturate local counters at the top, then at the bottom
        for (int i = 0; i < 30; i++) step(32'h0000_0300, 1, 32'h0000_0300, 1'b1);
        for (int i = 0; i < 30; i++) step(32'h0000_0300, 1, 32'h0000_0300, 1'b0);
        // R2/R5: two addresses aliasing on bits [11:2]
        for (int i = 0; i < 120; i++)
            step(i[0] ? 32'h2000_0104 : 32'h1000_0104, 1,
                 i[1] ? 32'h2000_0104 : 32'h1000_0104, (i % 3) == 0);
        // R8 R10: random mix, lookup and update addresses differ
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = 32'h4000_0000 | (32'($urandom_range(0, 15)) << 2);
            b = 32'h4000_0000 | (32'($urandom_range(0, 15)) << 2);
            step(a, ($urandom_range(0, 7) != 0), b, ($urandom_range(0, 2) != 0));
        end
        // R1: reset in mid-run restores initial outputs
        @(negedge clk);
        rst = 1'b1; up_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R1 local after rerst", lk_local, 1'b0);
        chk("R1 choice after rerst", lk_use_global, 1'b0);
        for (int i = 0; i < 50; i++)
            step(32'h4000_0100, 1, 32'h4000_0100, (i % 5) != 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule